// File: doc/BRIEF.md
# Compare-Driven Waveform Timer Channel

This block is one 16-bit up-counting timer channel that sits behind a small register interface. The counter advances on one of several clock-enable inputs, picked by a select field, and compares its value against two registers, A and C. A match on either one can drive a waveform pin, and a match on C can also restart the count at zero, stop the count, or both. Only the mode bits decide whether the channel runs free, runs as a periodic tick, fires once, or makes a PWM-like signal.

Software starts, halts and restarts the channel through a write-only control word. Compare events latch into status flags. Each flag can raise the interrupt output through an enable mask, which is set and cleared through two separate write addresses. A read of the status word returns the flags and clears them.

Top module: `wave_timer_chan`

## Requirements
- R1: After reset the count, status flags, interrupt mask, `wave_out` and `irq` are all zero, and the channel is stopped.
- R2: Mode bits [2:0] pick the count enable: a value i below NTAP (5) uses `tick_in[i]`, and any larger value never advances the counter. The counter advances by one on each clock edge where it is running and the selected enable is high.
- R3: With mode bit 3 (auto-restart) clear, the counter runs past compare C and wraps from 0xFFFF to 0. The wrap sets status bit 2.
- R4: With mode bit 3 set, an advancing edge at which the count equals compare C loads 0 instead of count+1.
- R5: With mode bit 4 (halt-on-C) set, a compare C match stops the channel. The count then holds, and status bit 8 (running, live) reads 0.
- R6: A compare C match sets status bit 0. A read of the status address (5) returns the flags and clears bits [2:0]. A flag set on the same edge as the read is kept.
- R7: `irq` is high exactly when a status flag is set whose mask bit is set. Writing address 3 ORs wdata[2:0] into the mask. Writing address 4 clears the mask bits set in wdata, so 0xFF masks every source.
- R8: Control address 6: bit 0 starts the count and bit 1 halts it. When both are written together, halt wins.
- R9: Control bit 2 (trigger) zeroes the count on that edge without changing the run state. Bit 0 together with bit 2 (0x5) restarts from 0 and runs.
- R10: The pin action for compare A is mode bits [6:5] and for compare C is mode bits [8:7], coded 0 none, 1 set, 2 clear, 3 toggle. The action is applied on the edge of the match.
- R11: When compare A and compare C match on the same edge, only the compare C action is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_in | input | NTAP | Candidate count enables |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address (0 mode, 1 cmp A, 2 cmp C, 3 mask set/read, 4 mask clear, 5 status, 6 control, 7 count) |
| wdata | input | CW | Write data |
| rdata | output | CW | Read data, registered, valid after the strobe edge |
| wave_out | output | 1 | Waveform pin |
| irq | output | 1 | Interrupt request |

## Verification
The collision that matters most is compare A and compare C landing on the same advancing edge, when both would change the pin. The bench sets both compares to the same value and uses the opposite actions (set against clear, and clear against set). It then follows the pin every cycle against an arithmetic model, which must show only the compare C action. A second collision, a status read on an edge that also raises a flag, is judged by reading the flags again afterwards.

// File: rtl/wtc_pkg.sv
package wtc_pkg;

  localparam int ADDR_W = 3;
  localparam int SEL_W  = 3;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_SET  = 2'd1,
    ACT_CLR  = 2'd2,
    ACT_TGL  = 2'd3
  } pin_act_e;

  typedef struct packed {
    pin_act_e         act_c;
    pin_act_e         act_a;
    logic             halt_on_c;
    logic             auto_rst;
    logic [SEL_W-1:0] clk_sel;
  } mode_t;

  localparam int MODE_W = $bits(mode_t);

  localparam logic [ADDR_W-1:0] A_MODE  = 3'd0;
  localparam logic [ADDR_W-1:0] A_CMPA  = 3'd1;
  localparam logic [ADDR_W-1:0] A_CMPC  = 3'd2;
  localparam logic [ADDR_W-1:0] A_MSET  = 3'd3;
  localparam logic [ADDR_W-1:0] A_MCLR  = 3'd4;
  localparam logic [ADDR_W-1:0] A_STAT  = 3'd5;
  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd6;
  localparam logic [ADDR_W-1:0] A_COUNT = 3'd7;

  localparam int FLG_N    = 3;
  localparam int FLG_C    = 0;
  localparam int FLG_A    = 1;
  localparam int FLG_WRAP = 2;
  localparam int RUN_BIT  = 8;

  localparam int CTL_START = 0;
  localparam int CTL_HALT  = 1;
  localparam int CTL_TRIG  = 2;

  function automatic logic apply_act(input pin_act_e act, input logic cur);
    case (act)
      ACT_SET: return 1'b1;
      ACT_CLR: return 1'b0;
      ACT_TGL: return ~cur;
      default: return cur;
    endcase
  endfunction

endpackage

// File: rtl/wtc_regs.sv
module wtc_regs
  import wtc_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CW-1:0]     wdata,
  input  logic              evt_a,
  input  logic              evt_c,
  input  logic              evt_wrap,
  input  logic [CW-1:0]     cnt,
  input  logic              running,
  output mode_t             mode,
  output logic [CW-1:0]     cmpa,
  output logic [CW-1:0]     cmpc,
  output logic              start,
  output logic              halt,
  output logic              trig,
  output logic [CW-1:0]     rdata,
  output logic              irq
);

  logic [FLG_N-1:0] flags_q, flags_d, mask_q, mask_d, evt_vec;
  logic             rd_status, ctrl_wr;
  logic [CW-1:0]    rdata_d;
  logic             irq_q;

  assign ctrl_wr   = wr_en && (addr == A_CTRL);
  assign start     = ctrl_wr && wdata[CTL_START];
  assign halt      = ctrl_wr && wdata[CTL_HALT];
  assign trig      = ctrl_wr && wdata[CTL_TRIG];
  assign rd_status = rd_en && (addr == A_STAT);

  always_comb begin
    evt_vec           = '0;
    evt_vec[FLG_C]    = evt_c;
    evt_vec[FLG_A]    = evt_a;
    evt_vec[FLG_WRAP] = evt_wrap;
  end

  // events win over a clearing read on the same edge
  assign flags_d = (rd_status ? '0 : flags_q) | evt_vec;

  always_comb begin
    mask_d = mask_q;
    if (wr_en && addr == A_MSET) mask_d = mask_q | wdata[FLG_N-1:0];
    else if (wr_en && addr == A_MCLR) mask_d = mask_q & ~wdata[FLG_N-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode <= '0;
      cmpa <= '0;
      cmpc <= '0;
    end else if (wr_en) begin
      case (addr)
        A_MODE: mode <= mode_t'(wdata[MODE_W-1:0]);
        A_CMPA: cmpa <= wdata;
        A_CMPC: cmpc <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_d = '0;
    case (addr)
      A_MODE:  rdata_d = CW'(mode);
      A_CMPA:  rdata_d = cmpa;
      A_CMPC:  rdata_d = cmpc;
      A_MSET:  rdata_d = CW'(mask_q);
      A_STAT: begin
        rdata_d[FLG_N-1:0] = flags_q;
        rdata_d[RUN_BIT]   = running;
      end
      A_COUNT: rdata_d = cnt;
      default: rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      mask_q  <= '0;
      irq_q   <= 1'b0;
      rdata   <= '0;
    end else begin
      flags_q <= flags_d;
      mask_q  <= mask_d;
      irq_q   <= |(flags_d & mask_d);
      if (rd_en) rdata <= rdata_d;
    end
  end

  assign irq = irq_q;

  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (rd_status && evt_vec == '0) |=> (flags_q == '0)); // R6
  AST_FLAG_KEEP: assert property (@(posedge clk) disable iff (rst)
    evt_c |=> flags_q[FLG_C]); // R6
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> ((flags_q & mask_q) != '0)); // R7

endmodule

// File: rtl/wtc_counter.sv
module wtc_counter
  import wtc_pkg::*;
#(
  parameter int CW   = 16,
  parameter int NTAP = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NTAP-1:0] tick_in,
  input  mode_t           mode,
  input  logic [CW-1:0]   cmpa,
  input  logic [CW-1:0]   cmpc,
  input  logic            start,
  input  logic            halt,
  input  logic            trig,
  output logic [CW-1:0]   cnt,
  output logic            running,
  output logic            evt_a,
  output logic            evt_c,
  output logic            evt_wrap
);

  localparam logic [CW-1:0] CNT_TOP = '1;

  logic          tick, adv;
  logic [CW-1:0] cnt_d;
  logic          run_d;

  always_comb begin
    tick = 1'b0;
    for (int i = 0; i < NTAP; i++) begin
      if (mode.clk_sel == SEL_W'(i)) tick = tick_in[i];
    end
  end

  assign adv      = running && tick && !trig;
  assign evt_c    = adv && (cnt == cmpc);
  assign evt_a    = adv && (cnt == cmpa);
  assign evt_wrap = adv && (cnt == CNT_TOP) && !(evt_c && mode.auto_rst);

  always_comb begin
    cnt_d = cnt;
    if (trig) cnt_d = '0;
    else if (adv) cnt_d = (evt_c && mode.auto_rst) ? '0 : cnt + 1'b1;
  end

  always_comb begin
    run_d = running;
    if (halt) run_d = 1'b0;
    else if (start) run_d = 1'b1;
    else if (evt_c && mode.halt_on_c) run_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      running <= 1'b0;
    end else begin
      cnt     <= cnt_d;
      running <= run_d;
    end
  end

  AST_TRIG_ZERO: assert property (@(posedge clk) disable iff (rst)
    trig |=> (cnt == '0)); // R9
  AST_HALT_WINS: assert property (@(posedge clk) disable iff (rst)
    halt |=> !running); // R8
  AST_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (!running && !trig) |=> $stable(cnt)); // R5
  AST_AUTO_RESTART: assert property (@(posedge clk) disable iff (rst)
    (evt_c && mode.auto_rst) |=> (cnt == '0)); // R4
  AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (rst)
    (evt_c && mode.halt_on_c && !start) |=> !running); // R5
  AST_FREE_WRAP: assert property (@(posedge clk) disable iff (rst)
    evt_wrap |=> (cnt == '0)); // R3

endmodule

// File: rtl/wtc_wave.sv
module wtc_wave
  import wtc_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     evt_a,
  input  logic     evt_c,
  input  pin_act_e act_a,
  input  pin_act_e act_c,
  output logic     wave
);

  logic wave_q, wave_d;

  always_comb begin
    wave_d = wave_q;
    if (evt_c) wave_d = apply_act(act_c, wave_q);
    else if (evt_a) wave_d = apply_act(act_a, wave_q);
  end

  always_ff @(posedge clk) begin
    if (rst) wave_q <= 1'b0;
    else wave_q <= wave_d;
  end

  assign wave = wave_q;

  AST_C_WINS_SET: assert property (@(posedge clk) disable iff (rst)
    (evt_a && evt_c && act_c == ACT_SET) |=> wave_q); // R11
  AST_C_WINS_CLR: assert property (@(posedge clk) disable iff (rst)
    (evt_a && evt_c && act_c == ACT_CLR) |=> !wave_q); // R11
  AST_PIN_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!evt_a && !evt_c) |=> $stable(wave_q)); // R10

endmodule

// File: rtl/wave_timer_chan.sv
module wave_timer_chan
  import wtc_pkg::*;
#(
  parameter int CW   = 16,
  parameter int NTAP = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NTAP-1:0]   tick_in,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CW-1:0]     wdata,
  output logic [CW-1:0]     rdata,
  output logic              wave_out,
  output logic              irq
);

  mode_t         mode;
  logic [CW-1:0] cmpa, cmpc, cnt;
  logic          start, halt, trig, running;
  logic          evt_a, evt_c, evt_wrap;

  wtc_regs #(.CW(CW)) regs_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .evt_a(evt_a), .evt_c(evt_c), .evt_wrap(evt_wrap),
    .cnt(cnt), .running(running), .mode(mode), .cmpa(cmpa), .cmpc(cmpc),
    .start(start), .halt(halt), .trig(trig), .rdata(rdata), .irq(irq)
  );

  wtc_counter #(.CW(CW), .NTAP(NTAP)) cnt_i (
    .clk(clk), .rst(rst), .tick_in(tick_in), .mode(mode), .cmpa(cmpa),
    .cmpc(cmpc), .start(start), .halt(halt), .trig(trig), .cnt(cnt),
    .running(running), .evt_a(evt_a), .evt_c(evt_c), .evt_wrap(evt_wrap)
  );

  wtc_wave wave_i (
    .clk(clk), .rst(rst), .evt_a(evt_a), .evt_c(evt_c),
    .act_a(mode.act_a), .act_c(mode.act_c), .wave(wave_out)
  );

endmodule

// File: tb/wave_timer_chan_tb_top.sv
module wave_timer_chan_tb_top;
  import wtc_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] cyc = '0;
  logic [4:0]  tick_in;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        wave_out, irq;

  int checks = 0, fails = 0;
  bit done = 0;

  int m_cnt, m_run, m_wave, m_cflag, m_wrap, m_edge;
  int m_sel, m_auto, m_stop, m_a, m_c, m_acta, m_actc;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign tick_in = {cyc[1:0] == 2'b11, 1'b0, 1'b0, cyc[0], 1'b1};

  wave_timer_chan dut_i (
    .clk(clk), .rst(rst), .tick_in(tick_in), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .wave_out(wave_out), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit tick_at(input int sel, input int j);
    int v = j - 1;
    case (sel)
      0: return 1'b1;
      1: return (v % 2) == 1;
      4: return (v % 4) == 3;
      default: return 1'b0;
    endcase
  endfunction

  function automatic int act_fn(input int a, input int cur);
    case (a)
      1: return 1;
      2: return 0;
      3: return 1 - cur;
      default: return cur;
    endcase
  endfunction

  task automatic model_to(input int k);
    while (m_edge < k) begin
      m_edge++;
      if (m_run != 0 && tick_at(m_sel, m_edge)) begin
        int old = m_cnt;
        bit mc = (old == m_c);
        bit ma = (old == m_a);
        m_cnt = (mc && m_auto != 0) ? 0 : (old + 1) % 65536;
        if (mc && m_stop != 0) m_run = 0;
        if (mc) m_cflag = 1;
        if (old == 65535 && !(mc && m_auto != 0)) m_wrap = 1;
        if (mc) m_wave = act_fn(m_actc, m_wave);
        else if (ma) m_wave = act_fn(m_acta, m_wave);
      end
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    v = int'(rdata);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    m_cnt = 0; m_run = 0; m_wave = 0; m_cflag = 0; m_wrap = 0;
    m_sel = 0; m_auto = 0; m_stop = 0; m_a = 0; m_c = 0; m_acta = 0; m_actc = 0;
    m_edge = int'(cyc);
  endtask

  task automatic set_mode(input int sel, input int au, input int st, input int aa, input int ac);
    wr(A_MODE, 16'((ac << 7) | (aa << 5) | (st << 4) | (au << 3) | sel));
    m_sel = sel; m_auto = au; m_stop = st; m_acta = aa; m_actc = ac;
  endtask

  task automatic set_cmp(input int a, input int c);
    wr(A_CMPA, 16'(a));
    wr(A_CMPC, 16'(c));
    m_a = a; m_c = c;
  endtask

  task automatic start_run();
    wr(A_CTRL, 16'h5);
    model_to(int'(cyc) - 1);
    m_cnt = 0; m_run = 1; m_edge = int'(cyc);
  endtask

  task automatic chk_count(input string req);
    int v;
    rd(A_COUNT, v);
    model_to(int'(cyc) - 1);
    chk(req, v, m_cnt);
  endtask

  initial begin
    int v, a, b;
    int sels[3] = '{0, 1, 4};
    int cs[3]   = '{0, 2, 5};
    // cfg: sel, actA, actC, A, C
    int wcfg[6][5] = '{'{0, 1, 2, 2, 7}, '{1, 3, 0, 3, 5}, '{0, 2, 1, 1, 6},
                       '{0, 1, 2, 3, 3}, '{0, 2, 1, 3, 3}, '{1, 1, 2, 4, 4}};

    // R1 reset state
    do_reset();
    chk("R1 wave", int'(wave_out), 0);
    chk("R1 irq", int'(irq), 0);
    rd(A_COUNT, v); chk("R1 count", v, 0);
    rd(A_STAT, v);  chk("R1 status", v, 0);
    rd(A_MSET, v);  chk("R1 mask", v, 0);

    // R2 / R4 count sweep over enable selects, restart mode, compare C
    for (int si = 0; si < 3; si++)
      for (int au = 0; au < 2; au++)
        for (int ci = 0; ci < 3; ci++) begin
          do_reset();
          set_mode(sels[si], au, 0, 0, 0);
          set_cmp(0, cs[ci]);
          start_run();
          for (int w = 0; w < 10; w++) begin
            repeat (w) @(negedge clk);
            chk_count(au != 0 ? "R4 auto-restart count" : "R2 selected-enable count");
          end
        end

    // R2 out-of-range select never counts
    do_reset();
    set_mode(6, 0, 0, 0, 0);
    start_run();
    repeat (10) @(negedge clk);
    rd(A_COUNT, v); chk("R2 unused select", v, 0);

    // R5 / R6 / R7 one-shot with interrupt
    do_reset();
    set_mode(0, 1, 1, 0, 0);
    set_cmp(0, 4);
    wr(A_MSET, 16'h1);
    start_run();
    repeat (20) @(negedge clk);
    chk_count("R5 one-shot final count");
    repeat (5) @(negedge clk);
    chk_count("R5 one-shot holds");
    chk("R7 irq on enabled flag", int'(irq), 1);
    wr(A_MCLR, 16'hFF);
    chk("R7 irq masked", int'(irq), 0);
    wr(A_MSET, 16'h1);
    chk("R7 irq re-enabled", int'(irq), 1);
    rd(A_STAT, v);
    chk("R6 compare C flag", v & 1, 1);
    chk("R5 running bit clear", (v >> 8) & 1, 0);
    chk("R7 irq after clearing read", int'(irq), 0);
    rd(A_STAT, v);
    chk("R6 flag cleared by read", v & 1, 0);

    // R6 flag raised on the same edge as a clearing read is kept
    do_reset();
    set_mode(0, 1, 0, 0, 0);
    set_cmp(0, 0);
    start_run();
    repeat (3) @(negedge clk);
    rd(A_STAT, v);
    chk("R6 flag while periodic", v & 1, 1);
    rd(A_STAT, v);
    chk("R6 same-edge flag kept", v & 1, 1);

    // R8 halt priority and resume
    do_reset();
    set_mode(0, 0, 0, 0, 0);
    set_cmp(0, 16'hFFFF);
    start_run();
    repeat (5) @(negedge clk);
    wr(A_CTRL, 16'h3);
    model_to(int'(cyc)); m_run = 0;
    chk_count("R8 halted count");
    repeat (5) @(negedge clk);
    chk_count("R8 count holds while halted");
    rd(A_STAT, v); chk("R8 running bit after start+halt", (v >> 8) & 1, 0);
    wr(A_CTRL, 16'h1);
    model_to(int'(cyc)); m_run = 1;
    repeat (3) @(negedge clk);
    chk_count("R8 resumed count");

    // R9 trigger while running, then while stopped
    repeat (7) @(negedge clk);
    wr(A_CTRL, 16'h4);
    model_to(int'(cyc) - 1); m_cnt = 0; m_edge = int'(cyc);
    chk_count("R9 trigger restarts running count");
    wr(A_CTRL, 16'h2);
    model_to(int'(cyc)); m_run = 0;
    wr(A_CTRL, 16'h4);
    model_to(int'(cyc) - 1); m_cnt = 0; m_edge = int'(cyc);
    repeat (4) @(negedge clk);
    chk_count("R9 trigger while stopped");
    rd(A_STAT, v); chk("R9 trigger keeps stopped", (v >> 8) & 1, 0);

    // R10 / R11 pin actions, followed every cycle
    for (int k = 0; k < 6; k++) begin
      do_reset();
      set_mode(wcfg[k][0], 1, 0, wcfg[k][1], wcfg[k][2]);
      set_cmp(wcfg[k][3], wcfg[k][4]);
      start_run();
      for (int n = 0; n < 40; n++) begin
        @(negedge clk);
        model_to(int'(cyc));
        chk(wcfg[k][3] == wcfg[k][4] ? "R11 compare C action wins" : "R10 pin action",
            int'(wave_out), m_wave);
      end
    end

    // R3 free-run wrap
    do_reset();
    set_mode(0, 0, 0, 0, 0);
    set_cmp(0, 100);
    start_run();
    repeat (65540) @(negedge clk);
    chk_count("R3 count after wrap");
    rd(A_STAT, v);
    model_to(int'(cyc) - 1);
    chk("R3 wrap flag", (v >> 2) & 1, m_wrap);
    chk("R3 wrap flag set", (v >> 2) & 1, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog (all requirements) actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule